// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Bank

This block is a bank of six rate generators that all run in one system clock domain. Three input rate streams come in as single-cycle enable pulses: a core-PLL tick, an auxiliary-PLL tick and a second auxiliary-PLL tick. Each generator selects one stream, counts its pulses and issues one single-cycle output pulse each time a programmable number of them has arrived. A generator can also be switched off. Downstream logic uses each output pulse as a clock enable.

Two 32-bit control words hold the settings, three generators to a word, and a simple write/read port gives access to them. A strap pin is sampled while reset is held and fixes how the fields are decoded. In legacy decoding a generator has a source bit and an enable bit, and it divides only by even amounts. In extended decoding a 2-bit selector picks among three sources, with code 0 meaning off. Each word also carries a shared scale bit that allows any divisor from 1 to 256.

Top module: `clkgen_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both control words read as zero and no generator issues a pulse.
- R2: A read returns exactly the 32-bit value last written to the selected word (select 0 is the first word, select 1 the second). A write to one word leaves the other word unchanged.
- R3: Generator g takes its 10-bit field from word g/3, at bits 10*(g%3)+9 down to 10*(g%3). Within a field, bits 9:2 hold the divider code N.
- R4: Legacy decoding (strap 0): field bit 0 chooses the source (0 = core tick, 1 = auxiliary tick) and field bit 1 is the enable. When the enable is 0 the generator issues no pulses.
- R5: Legacy decoding divides by 2*(N+1), which covers 2 to 512. Bit 30 of a word has no effect in this mode.
- R6: Extended decoding (strap 1): field bits 1:0 select the source. Code 0 turns the generator off, 1 selects the second auxiliary tick, 2 the core tick and 3 the auxiliary tick.
- R7: Extended decoding: bit 30 of a word is a scale bit shared by that word's three generators. When it is set the divisor is N+1 (1 to 256). When it is clear the divisor is 2*(N+1).
- R8: An enabled generator issues one single-cycle pulse for every divisor-count of selected-input pulses. The output pulse appears one cycle after the input pulse that completes the count, so the spacing between output pulses equals the divisor times the input pulse spacing.
- R9: A change of source or divider code on a running generator takes effect only after the next output pulse, so the period already in progress finishes with the old settings. Switching a generator off stops its pulses from the cycle after the write and clears its count.
- R10: The strap is sampled only while reset is asserted. Changing it after reset does not alter the decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_strap | input | 1 | Decoding select, sampled during reset (0 legacy, 1 extended) |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Word selected for the write |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | Word selected for the read |
| rd_data | output | 32 | Read value of the selected word |
| core_tick | input | 1 | Core-PLL rate pulse |
| aux_tick | input | 1 | Auxiliary-PLL rate pulse |
| aux2_tick | input | 1 | Second auxiliary-PLL rate pulse |
| gen_tick | output | 6 | One output enable pulse per generator |

## Verification
The bench drives the three input streams at spacings of 1, 2 and 3 cycles. A wrong source decode therefore changes the measured output spacing, and it does not merely shift its phase. It tests both ends of each divider range: code 255 must give 512 in legacy and in scaled-off extended decoding, and 256 times the input spacing with the scale bit set. An off-by-one in the counter limit, or an ignored scale bit, shows up as a wrong spacing. It rewrites the divider in the middle of a period and checks that this period still has the old length and the next one has the new length; a design that reloads at once would produce one short period. It also checks that the scale bit is ignored in legacy decoding, that a disabled field with a nonzero code stays silent, and that a strap change after reset does not change the decoding.

// File: rtl/clkgen_pkg.sv
// Package: clkgen_pkg
// Shared constants and types for the divider bank.
// Assumes the field layout below is fixed across every instance.
package clkgen_pkg;

    localparam int CODE_W    = 8;            // divider code width
    localparam int LIM_W     = CODE_W + 1;   // count limit width (divisor - 1)
    localparam int SRC_NUM   = 4;            // padded source vector width
    localparam int FLD_ENB   = 1;            // legacy enable bit in a field
    localparam int FLD_SRC   = 0;            // legacy source bit in a field
    localparam int FLD_CODE  = 2;            // lsb of divider code in a field

    typedef enum logic [1:0] {
        SRC_CORE = 2'd0,
        SRC_AUX  = 2'd1,
        SRC_AUX2 = 2'd2
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [LIM_W-1:0] lim;   // divisor minus one
    } gen_cfg_t;

endpackage

// File: rtl/clkgen_regs.sv
// Module: clkgen_regs
// Holds the control words and the decode-mode strap.
// Assumes one write per cycle; reads are combinational.
module clkgen_regs #(
    parameter int DATA_W  = 32,
    parameter int NUM_REG = 2,
    parameter int SEL_W   = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_strap,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [SEL_W-1:0]          rd_sel,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_REG*DATA_W-1:0] regs_flat,
    output logic                      ext_mode
);

    logic [DATA_W-1:0] word_q [NUM_REG];
    logic              ext_q;

    // Capture the strap while reset is held; keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= mode_strap;
    end

    for (genvar r = 0; r < NUM_REG; r++) begin : g_word
        // Store one control word on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[r] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(r)))
                word_q[r] <= wr_data;
        end
        assign regs_flat[r*DATA_W +: DATA_W] = word_q[r];
    end

    assign rd_data  = word_q[rd_sel];
    assign ext_mode = ext_q;

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

    // R10
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(ext_q));

endmodule

// File: rtl/clkgen_decode.sv
// Module: clkgen_decode
// Turns one 10-bit field plus word scale bit into enable, source and limit.
// Assumes the mode input is static after reset. Purely combinational.
module clkgen_decode
    import clkgen_pkg::*;
#(
    parameter int SLOT_W = 10
) (
    input  logic              ext_mode,
    input  logic              scale,
    input  logic [SLOT_W-1:0] slot,
    output logic              en,
    output gen_cfg_t          cfg
);

    logic [CODE_W-1:0] code;
    assign code = slot[FLD_CODE +: CODE_W];

    // Decode the field according to the strapped mode.
    always_comb begin
        if (!ext_mode) begin
            en      = slot[FLD_ENB];
            cfg.src = slot[FLD_SRC] ? SRC_AUX : SRC_CORE;
            cfg.lim = {code, 1'b1};
        end else begin
            en = (slot[1:0] != 2'd0);
            unique case (slot[1:0])
                2'd1:    cfg.src = SRC_AUX2;
                2'd3:    cfg.src = SRC_AUX;
                default: cfg.src = SRC_CORE;
            endcase
            cfg.lim = scale ? {1'b0, code} : {code, 1'b1};
        end
    end

endmodule

// File: rtl/clkgen_counter.sv
// Module: clkgen_counter
// Counts selected input pulses and emits one output pulse per divisor.
// Assumes the live settings may change any cycle; they are taken up only
// at an output boundary or while idle.
module clkgen_counter
    import clkgen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  gen_cfg_t           live_cfg,
    input  logic [SRC_NUM-1:0] ticks,
    output logic               tick_out
);

    gen_cfg_t          act_q;
    gen_cfg_t          eff;
    logic              run_q;
    logic [LIM_W-1:0]  cnt_q;
    logic              sel;
    logic              hit;
    logic              out_q;

    assign eff = run_q ? act_q : live_cfg;
    assign sel = ticks[eff.src];
    assign hit = en && sel && (cnt_q == eff.lim);

    // Count, emit, and take up new settings at boundaries or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            act_q <= '0;
            out_q <= 1'b0;
        end else begin
            run_q <= en;
            out_q <= hit;
            if (!en)
                cnt_q <= '0;
            else if (sel)
                cnt_q <= hit ? '0 : cnt_q + 1'b1;
            if (!en || !run_q || hit)
                act_q <= live_cfg;
        end
    end

    assign tick_out = out_q;

    // R4 R6 R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick_out);

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= act_q.lim));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en && !hit) |=> $stable(act_q));

endmodule

// File: rtl/clkgen_bank.sv
// Module: clkgen_bank
// Six rate generators fed from two packed control words.
// Assumes all input ticks are single-cycle pulses in the clk domain.
module clkgen_bank
    import clkgen_pkg::*;
#(
    parameter int NUM_GEN   = 6,
    parameter int GEN_PER_W = 3,
    parameter int SLOT_W    = 10,
    parameter int DATA_W    = 32,
    parameter int SCALE_BIT = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_strap,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               core_tick,
    input  logic               aux_tick,
    input  logic               aux2_tick,
    output logic [NUM_GEN-1:0] gen_tick
);

    localparam int NUM_REG = NUM_GEN / GEN_PER_W;

    logic [NUM_REG*DATA_W-1:0] regs_flat;
    logic                      ext_mode;
    logic [SRC_NUM-1:0]        ticks;

    assign ticks = {1'b0, aux2_tick, aux_tick, core_tick};

    clkgen_regs #(
        .DATA_W  (DATA_W),
        .NUM_REG (NUM_REG),
        .SEL_W   (1)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_strap (mode_strap),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .regs_flat  (regs_flat),
        .ext_mode   (ext_mode)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        localparam int BASE = (g / GEN_PER_W) * DATA_W;
        logic     en;
        gen_cfg_t cfg;

        clkgen_decode #(.SLOT_W(SLOT_W)) dec_i (
            .ext_mode (ext_mode),
            .scale    (regs_flat[BASE + SCALE_BIT]),
            .slot     (regs_flat[BASE + (g % GEN_PER_W)*SLOT_W +: SLOT_W]),
            .en       (en),
            .cfg      (cfg)
        );

        clkgen_counter cnt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .live_cfg (cfg),
            .ticks    (ticks),
            .tick_out (gen_tick[g])
        );
    end

endmodule

// File: tb/clkgen_bank_tb.sv
// Module: clkgen_bank_tb_top
// Directed bench: one task per scenario, each checking its own results.
module clkgen_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_strap = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        core_tick = 1'b0;
    logic        aux_tick = 1'b0;
    logic        aux2_tick = 1'b0;
    logic [5:0]  gen_tick;

    int cyc = 0;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Cycle count used to time output pulses.
    always @(posedge clk) cyc <= cyc + 1;

    // Input streams: core every cycle, aux every 2nd, aux2 every 3rd.
    initial begin
        forever begin
            @(negedge clk);
            core_tick = 1'b1;
            aux_tick  = (cyc % 2 == 0);
            aux2_tick = (cyc % 3 == 0);
        end
    end

    clkgen_bank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_strap (mode_strap),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .core_tick  (core_tick),
        .aux_tick   (aux_tick),
        .aux2_tick  (aux2_tick),
        .gen_tick   (gen_tick)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        mode_strap = strap;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = sel;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic wait_pulse(input int g, output int t);
        int n = 0;
        t = -1;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (gen_tick[g]) begin
                t = cyc;
                break;
            end
        end
    endtask

    task automatic measure(input int g, output int per);
        int t1, t2, t3;
        wait_pulse(g, t1);
        wait_pulse(g, t2);
        wait_pulse(g, t3);
        per = (t1 < 0 || t2 < 0 || t3 < 0) ? -1 : (t3 - t2);
    endtask

    task automatic quiet(input int g, input int ncyc, output int cnt);
        cnt = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (gen_tick[g]) cnt++;
        end
    endtask

    function automatic logic [31:0] fld(input int pos, input logic [9:0] v);
        return {22'd0, v} << (10 * pos);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        int c;
        do_reset(1'b0);
        rd(1'b0, d); chk("R1 word0 after reset", d, 0);
        rd(1'b1, d); chk("R1 word1 after reset", d, 0);
        quiet(0, 40, c); chk("R1 gen0 silent", c, 0);
        quiet(5, 40, c); chk("R1 gen5 silent", c, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(1'b0, 32'hA5A5_5A5A);
        wr(1'b1, 32'h3C3C_C3C3);
        rd(1'b0, d); chk("R2 word0 readback", d, 32'hA5A5_5A5A);
        rd(1'b1, d); chk("R2 word1 readback", d, 32'h3C3C_C3C3);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b0, d); chk("R2 word0 untouched by word1 write", d, 32'hA5A5_5A5A);
        wr(1'b0, 32'h0);
        wr(1'b1, 32'h0);
    endtask

    task automatic t_legacy();
        int p, c;
        // gen0 core N=0; gen2 core N=255
        wr(1'b0, fld(0, 10'h002) | fld(2, 10'h3FE));
        // gen3 enable clear N=5 src aux; gen4 aux N=3
        wr(1'b1, fld(0, 10'h015) | fld(1, 10'h00F));
        measure(0, p); chk("R5 R8 legacy core N=0 spacing", p, 2);
        measure(2, p); chk("R3 R5 legacy N=255 spacing", p, 512);
        measure(4, p); chk("R3 R4 legacy aux N=3 spacing", p, 16);
        quiet(3, 200, c); chk("R4 legacy enable clear", c, 0);
        wr(1'b0, 32'h4000_0000 | fld(0, 10'h002));
        measure(0, p); chk("R5 scale bit ignored in legacy", p, 2);
    endtask

    task automatic t_reload();
        int p, t0, t1, t2, c;
        wr(1'b1, 32'h0);
        wr(1'b0, fld(0, 10'h00E));          // core N=3 -> 8
        measure(0, p); chk("R8 legacy core N=3 spacing", p, 8);
        wait_pulse(0, t0);
        repeat (2) @(negedge clk);
        wr(1'b0, fld(0, 10'h002));          // N=0 mid period
        wait_pulse(0, t1);
        wait_pulse(0, t2);
        chk("R9 period in progress keeps old divisor", t1 - t0, 8);
        chk("R9 new divisor after boundary", t2 - t1, 2);
        wr(1'b0, 32'h0);
        quiet(0, 30, c); chk("R9 disable stops pulses", c, 0);
    endtask

    task automatic t_extended();
        int p, c;
        do_reset(1'b1);
        // scale set: gen0 code0 N=4, gen1 aux2 N=4, gen2 core N=2
        wr(1'b0, 32'h4000_0000 | fld(0, 10'h010) | fld(1, 10'h011)
                 | fld(2, 10'h00A));
        // scale clear: gen3 core N=2, gen4 aux N=0
        wr(1'b1, fld(0, 10'h00A) | fld(1, 10'h003));
        quiet(0, 200, c); chk("R6 code 0 disabled", c, 0);
        measure(1, p); chk("R6 R7 aux2 scaled N=4", p, 15);
        measure(2, p); chk("R6 R7 core scaled N=2", p, 3);
        measure(3, p); chk("R7 core unscaled N=2", p, 6);
        measure(4, p); chk("R6 R7 aux unscaled N=0", p, 4);
        wr(1'b0, 32'h4000_0000 | fld(0, 10'h3FF));
        measure(0, p); chk("R7 scaled N=255 aux", p, 512);
    endtask

    task automatic t_strap_hold();
        int p;
        @(negedge clk);
        mode_strap = 1'b0;
        wr(1'b0, 32'h4000_0000 | fld(0, 10'h011));
        measure(0, p); chk("R10 strap change after reset ignored", p, 15);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_legacy();
        t_reload();
        t_extended();
        t_strap_hold();
        summary();
    end

endmodule